// File: doc/BRIEF.md
# Power-management companion register file

This block is the register file of a power-management companion chip. A serial bus slave sits in front of it and turns each bus frame into one access on a simple register port: a strobe, a write flag, a 5-bit register index and 16 bits of write data. Reads return their data on a registered output.

The file holds the following state:
- an interrupt status word whose bits the host flips by writing ones;
- an interrupt mask, with one bit per source;
- a 16-channel table of preset ADC results, read through a channel-select register;
- a sample-control word that the host clears by writing ones;
- two general control words and a calibration word;
- a key-status word;
- a watchdog register. Writing zero to it while the watchdog is enabled raises a one-cycle shutdown request.

A power-key event input sets the key interrupt and records whether the key is up or down. A strap input selects which of two chip identities the ID register reports. The interrupt output is high when any unmasked status bit is set.

Register indices: 0 ID, 1 interrupt status, 2 interrupt mask, 3 calibration, 4 ADC, 5 sample control, 6 control 1, 7 control 2, 8 key status, 9 watchdog. Indices 10 to 31 are unimplemented.

Top module: `pmic_regfile`

## Requirements
- R1: After reset the registers hold these values: interrupt mask 0xFFFF, interrupt status 0x0000, calibration 0x0001, key status 0x0020, sample control 0x00FF, control 1 0x0000, control 2 0x0000. After reset `irq_o` and `shutdown_o` are 0.
- R2: `irq_o` is 1 exactly when (status AND NOT mask) is nonzero. It reflects a register write from the cycle after the write strobe.
- R3: A write to index 1 XORs the write data into the interrupt status word. Writing a 1 to a set bit clears it, and writing a 1 to a clear bit sets it.
- R4: A cycle with `key_evt_i` high sets status bit 0. In that same cycle, bit 5 of the key status word (index 8) takes the value NOT `key_down_i`: 0 while the key is pressed, 1 while it is released.
- R5: A write to index 4 selects the ADC channel from write-data bits 13..10 and sets status bit 8. A read of index 4 returns the channel in bits 13..10 and that channel's result in bits 9..0. The other bits read as 0. The result for channel c is (37*c+5) mod 1024.
- R6: A write to index 5 clears every sample-control bit that is 1 in the write data. All other bits keep their value.
- R7: Index 0 reads 0x0215 when `variant_i` is 0 and 0x0295 (bit 7 set) when `variant_i` is 1.
- R8: The shutdown request fires only when index 9 is written with the value 0x0000 while bit 1 of control 1 is set. It is then a one-cycle pulse on `shutdown_o` in the cycle after the write strobe. A nonzero write, or a write while that bit is clear, gives no pulse.
- R9: Indices 10 to 31 read as 0, and writes to them change no register.
- R10: `rdata_o` loads the addressed register in the cycle after a read strobe. It holds that value through idle cycles and through writes.
- R11: Indices 2, 3, 6 and 7 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| variant_i | input | 1 | Identity strap, sets bit 7 of the ID register |
| acc_en_i | input | 1 | Access strobe, one cycle per access |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_idx_i | input | 5 | Register index |
| acc_wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| key_evt_i | input | 1 | Power-key event pulse |
| key_down_i | input | 1 | Key level sampled with the event, 1 = pressed |
| irq_o | output | 1 | Interrupt request |
| shutdown_o | output | 1 | One-cycle shutdown request |

## Verification
The bench walks each of the 16 status bits through set, mask, unmask and clear. A design that cleared bits on write instead of toggling them, or that inverted the mask sense, would fail on the first bit it touched.

The bench sweeps all 16 ADC channels and checks that each read packs the channel above the result and that each select raises bit 8. A mux indexed by a stale channel, or a missing sample interrupt, would show up on the first channel change.

The watchdog is fired with the enable bit set and clear, and with nonzero data. A design that latched the request, or fired it on any write, would hold or raise `shutdown_o` where the bench expects 0. Every unimplemented index is written and read back, which catches an aliased decode that spills onto a live register.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned IDX_W     = 5;
  localparam int unsigned ADC_CH    = 16;
  localparam int unsigned ADC_RES_W = 10;
  localparam int unsigned ADC_CH_LSB = 10;

  localparam int unsigned IX_ID    = 0;
  localparam int unsigned IX_STAT  = 1;
  localparam int unsigned IX_MASK  = 2;
  localparam int unsigned IX_CAL   = 3;
  localparam int unsigned IX_ADC   = 4;
  localparam int unsigned IX_SMP   = 5;
  localparam int unsigned IX_CTL1  = 6;
  localparam int unsigned IX_CTL2  = 7;
  localparam int unsigned IX_KEY   = 8;
  localparam int unsigned IX_WDG   = 9;

  localparam int unsigned IRQ_KEY_BIT  = 0;
  localparam int unsigned IRQ_ADC_BIT  = 8;
  localparam int unsigned KEY_UP_BIT   = 5;
  localparam int unsigned WDG_EN_BIT   = 1;
  localparam int unsigned ID_VAR_BIT   = 7;
  localparam logic [15:0] ID_BASE      = 16'h0215;

  typedef struct packed {
    logic stat;
    logic mask;
    logic cal;
    logic adc;
    logic smp;
    logic ctl1;
    logic ctl2;
    logic wdg;
  } wr_dec_t;

  function automatic logic [15:0] adc_preset(input int unsigned ch);
    return 16'((37 * ch + 5) % 1024);
  endfunction
endpackage

// File: rtl/pmic_irq.sv
module pmic_irq #(
  parameter int unsigned DW      = 16,
  parameter int unsigned KEY_BIT = 0,
  parameter int unsigned ADC_BIT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tog_we_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          key_evt_i,
  input  logic          adc_evt_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] stat_q, mask_q, set_vec, stat_d;

  always_comb begin
    set_vec          = '0;
    set_vec[KEY_BIT] = key_evt_i;
    set_vec[ADC_BIT] = adc_evt_i;
    // hardware set wins over a toggle in the same cycle
    stat_d = (stat_q ^ (tog_we_i ? wdata_i : '0)) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);
endmodule

// File: rtl/pmic_adc.sv
module pmic_adc #(
  parameter int unsigned DW     = 16,
  parameter int unsigned CH     = 16,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned CH_LSB = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned CH_W = $clog2(CH);

  logic [CH_W-1:0]  ch_q;
  logic [RES_W-1:0] tbl_q [CH];

  for (genvar g = 0; g < CH; g++) begin : g_tbl
    localparam logic [15:0] PV = pmic_pkg::adc_preset(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[g] <= PV[RES_W-1:0];
      else         tbl_q[g] <= tbl_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ch_q <= '0;
    else if (sel_we_i) ch_q <= wdata_i[CH_LSB +: CH_W];
  end

  always_comb begin
    rdata_o                  = '0;
    rdata_o[RES_W-1:0]       = tbl_q[ch_q];
    rdata_o[CH_LSB +: CH_W]  = ch_q;
  end
endmodule

// File: rtl/pmic_ctrl.sv
module pmic_ctrl #(
  parameter int unsigned DW         = 16,
  parameter logic [DW-1:0] CAL_RST  = 16'h0001,
  parameter logic [DW-1:0] SMP_RST  = 16'h00FF,
  parameter logic [DW-1:0] KEY_RST  = 16'h0020,
  parameter int unsigned KEY_UP_BIT = 5,
  parameter int unsigned WDG_EN_BIT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cal_we_i,
  input  logic          smp_we_i,
  input  logic          ctl1_we_i,
  input  logic          ctl2_we_i,
  input  logic          wdg_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          key_evt_i,
  input  logic          key_down_i,
  output logic [DW-1:0] cal_o,
  output logic [DW-1:0] smp_o,
  output logic [DW-1:0] ctl1_o,
  output logic [DW-1:0] ctl2_o,
  output logic [DW-1:0] key_o,
  output logic          shutdown_o
);
  logic [DW-1:0] cal_q, smp_q, ctl1_q, ctl2_q, key_q;
  logic          sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q  <= CAL_RST;
      smp_q  <= SMP_RST;
      ctl1_q <= '0;
      ctl2_q <= '0;
      key_q  <= KEY_RST;
      sd_q   <= 1'b0;
    end else begin
      if (cal_we_i)  cal_q  <= wdata_i;
      if (smp_we_i)  smp_q  <= smp_q & ~wdata_i;
      if (ctl1_we_i) ctl1_q <= wdata_i;
      if (ctl2_we_i) ctl2_q <= wdata_i;
      if (key_evt_i) key_q[KEY_UP_BIT] <= ~key_down_i;
      sd_q <= wdg_we_i && (wdata_i == '0) && ctl1_q[WDG_EN_BIT];
    end
  end

  assign cal_o      = cal_q;
  assign smp_o      = smp_q;
  assign ctl1_o     = ctl1_q;
  assign ctl2_o     = ctl2_q;
  assign key_o      = key_q;
  assign shutdown_o = sd_q;
endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile
  import pmic_pkg::*;
#(
  parameter int unsigned DW    = pmic_pkg::REG_W,
  parameter int unsigned IW    = pmic_pkg::IDX_W,
  parameter logic [DW-1:0] CAL_RST = 16'h0001,
  parameter logic [DW-1:0] SMP_RST = 16'h00FF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          variant_i,
  input  logic          acc_en_i,
  input  logic          acc_we_i,
  input  logic [IW-1:0] acc_idx_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          key_evt_i,
  input  logic          key_down_i,
  output logic          irq_o,
  output logic          shutdown_o
);
  wr_dec_t       wd;
  logic          wr, rd;
  logic [DW-1:0] irq_stat, irq_mask, adc_rd, cal, smp, ctl1, ctl2, keyst, id_val, rd_mux;
  logic [DW-1:0] rdata_q;

  assign wr = acc_en_i & acc_we_i;
  assign rd = acc_en_i & ~acc_we_i;

  always_comb begin
    wd      = '0;
    wd.stat = wr && (acc_idx_i == IW'(IX_STAT));
    wd.mask = wr && (acc_idx_i == IW'(IX_MASK));
    wd.cal  = wr && (acc_idx_i == IW'(IX_CAL));
    wd.adc  = wr && (acc_idx_i == IW'(IX_ADC));
    wd.smp  = wr && (acc_idx_i == IW'(IX_SMP));
    wd.ctl1 = wr && (acc_idx_i == IW'(IX_CTL1));
    wd.ctl2 = wr && (acc_idx_i == IW'(IX_CTL2));
    wd.wdg  = wr && (acc_idx_i == IW'(IX_WDG));
  end

  pmic_irq #(.DW(DW), .KEY_BIT(IRQ_KEY_BIT), .ADC_BIT(IRQ_ADC_BIT)) u_irq (
    .clk_i, .rst_ni,
    .tog_we_i  (wd.stat),
    .mask_we_i (wd.mask),
    .wdata_i   (acc_wdata_i),
    .key_evt_i (key_evt_i),
    .adc_evt_i (wd.adc),
    .stat_o    (irq_stat),
    .mask_o    (irq_mask),
    .irq_o     (irq_o)
  );

  pmic_adc #(.DW(DW), .CH(ADC_CH), .RES_W(ADC_RES_W), .CH_LSB(ADC_CH_LSB)) u_adc (
    .clk_i, .rst_ni,
    .sel_we_i (wd.adc),
    .wdata_i  (acc_wdata_i),
    .rdata_o  (adc_rd)
  );

  pmic_ctrl #(.DW(DW), .CAL_RST(CAL_RST), .SMP_RST(SMP_RST), .KEY_RST(DW'(1) << KEY_UP_BIT),
              .KEY_UP_BIT(KEY_UP_BIT), .WDG_EN_BIT(WDG_EN_BIT)) u_ctrl (
    .clk_i, .rst_ni,
    .cal_we_i   (wd.cal),
    .smp_we_i   (wd.smp),
    .ctl1_we_i  (wd.ctl1),
    .ctl2_we_i  (wd.ctl2),
    .wdg_we_i   (wd.wdg),
    .wdata_i    (acc_wdata_i),
    .key_evt_i  (key_evt_i),
    .key_down_i (key_down_i),
    .cal_o      (cal),
    .smp_o      (smp),
    .ctl1_o     (ctl1),
    .ctl2_o     (ctl2),
    .key_o      (keyst),
    .shutdown_o (shutdown_o)
  );

  always_comb begin
    id_val             = ID_BASE;
    id_val[ID_VAR_BIT] = variant_i;
  end

  always_comb begin
    unique case (int'(acc_idx_i))
      IX_ID:   rd_mux = id_val;
      IX_STAT: rd_mux = irq_stat;
      IX_MASK: rd_mux = irq_mask;
      IX_CAL:  rd_mux = cal;
      IX_ADC:  rd_mux = adc_rd;
      IX_SMP:  rd_mux = smp;
      IX_CTL1: rd_mux = ctl1;
      IX_CTL2: rd_mux = ctl2;
      IX_KEY:  rd_mux = keyst;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pmic_regfile_chk.sv
module pmic_regfile_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_en_i,
  input logic          acc_we_i,
  input logic [IW-1:0] acc_idx_i,
  input logic [DW-1:0] acc_wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          key_evt_i,
  input logic          irq_o,
  input logic          shutdown_o,
  input logic [DW-1:0] stat_i
);
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> !shutdown_o);

  a_r8_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> $past(acc_en_i && acc_we_i && acc_idx_i == IW'(9) && acc_wdata_i == '0));

  a_r5_adc_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && acc_we_i && acc_idx_i == IW'(4)) |=> stat_i[8]);

  a_r4_key_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_evt_i |=> stat_i[0]);

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_en_i && !acc_we_i) |=> $stable(rdata_o));

  a_r2_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((acc_en_i && acc_we_i) || key_evt_i));
endmodule

bind pmic_regfile pmic_regfile_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_en_i    (acc_en_i),
  .acc_we_i    (acc_we_i),
  .acc_idx_i   (acc_idx_i),
  .acc_wdata_i (acc_wdata_i),
  .rdata_o     (rdata_o),
  .key_evt_i   (key_evt_i),
  .irq_o       (irq_o),
  .shutdown_o  (shutdown_o),
  .stat_i      (irq_stat)
);

// File: tb/pmic_regfile_tb.sv
`timescale 1ns/1ps
module pmic_regfile_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        variant = 0;
  logic        en = 0, we = 0;
  logic [4:0]  idx = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        key_evt = 0, key_down = 0;
  logic        irq, sd;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pmic_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant),
    .acc_en_i(en), .acc_we_i(we), .acc_idx_i(idx), .acc_wdata_i(wdata),
    .rdata_o(rdata), .key_evt_i(key_evt), .key_down_i(key_down),
    .irq_o(irq), .shutdown_o(sd)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [15:0] d);
    en = 1; we = 1; idx = 5'(i); wdata = d;
    @(posedge clk); @(negedge clk);
    en = 0; we = 0;
  endtask

  task automatic rd(input int i, output logic [15:0] d);
    en = 1; we = 0; idx = 5'(i);
    @(posedge clk); @(negedge clk);
    en = 0;
    d = rdata;
  endtask

  task automatic key(input logic down);
    key_evt = 1; key_down = down;
    @(posedge clk); @(negedge clk);
    key_evt = 0;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 shutdown", 16'(sd), 16'h0);
    rd(2, v); chk("R1 mask", v, 16'hFFFF);
    rd(1, v); chk("R1 status", v, 16'h0000);
    rd(3, v); chk("R1 cal", v, 16'h0001);
    rd(8, v); chk("R1 keystat", v, 16'h0020);
    rd(5, v); chk("R1 sample", v, 16'h00FF);
    rd(6, v); chk("R1 ctl1", v, 16'h0000);
    rd(7, v); chk("R1 ctl2", v, 16'h0000);

    // R7 identity
    rd(0, v); chk("R7 id v0", v, 16'h0215);
    variant = 1;
    rd(0, v); chk("R7 id v1", v, 16'h0295);
    variant = 0;

    // R2 R3 sweep over all status bits
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = 16'(1) << i;
      wr(2, ~b);
      chk("R2 masked-clear irq", 16'(irq), 16'h0);
      wr(1, b);
      chk("R2 irq unmasked set", 16'(irq), 16'h1);
      rd(1, v); chk("R3 toggle set", v, b);
      wr(2, 16'hFFFF);
      chk("R2 irq all masked", 16'(irq), 16'h0);
      wr(2, ~b);
      wr(1, b);
      rd(1, v); chk("R3 toggle clear", v, 16'h0);
      chk("R2 irq after clear", 16'(irq), 16'h0);
    end
    wr(1, 16'h0F0F);
    wr(1, 16'h00FF);
    rd(1, v); chk("R3 xor pattern", v, 16'h0FF0);
    wr(1, 16'h0FF0);

    // R4 key events
    wr(2, 16'hFFFE);
    key(1);
    chk("R4 key irq", 16'(irq), 16'h1);
    rd(1, v); chk("R4 key status bit0", v, 16'h0001);
    rd(8, v); chk("R4 pressed bit5 clear", v, 16'h0000);
    key(0);
    rd(8, v); chk("R4 released bit5 set", v, 16'h0020);
    wr(1, 16'h0001);
    rd(1, v); chk("R4 cleared", v, 16'h0000);

    // R5 ADC sweep
    wr(2, 16'hFEFF);
    for (int c = 0; c < 16; c++) begin
      logic [15:0] e;
      e = 16'((c << 10) | ((37 * c + 5) % 1024));
      wr(4, 16'(c << 10) | 16'h8000);
      chk("R5 adc irq", 16'(irq), 16'h1);
      rd(1, v); chk("R5 adc status bit8", v, 16'h0100);
      rd(4, v); chk("R5 adc read", v, e);
      wr(1, 16'h0100);
      rd(1, v); chk("R5 adc clear", v, 16'h0000);
    end
    wr(2, 16'hFFFF);

    // R6 write-one-to-clear
    wr(5, 16'h000F); rd(5, v); chk("R6 w1c low", v, 16'h00F0);
    wr(5, 16'hFF00); rd(5, v); chk("R6 w1c no effect", v, 16'h00F0);
    wr(5, 16'h00F0); rd(5, v); chk("R6 w1c all", v, 16'h0000);

    // R11 plain read/write
    wr(6, 16'hA5A5); rd(6, v); chk("R11 ctl1", v, 16'hA5A5);
    wr(7, 16'h5A5A); rd(7, v); chk("R11 ctl2", v, 16'h5A5A);
    wr(3, 16'h1234); rd(3, v); chk("R11 cal", v, 16'h1234);
    wr(2, 16'h7FFF); rd(2, v); chk("R11 mask", v, 16'h7FFF);
    wr(2, 16'hFFFF);

    // R8 watchdog
    wr(6, 16'h0000);
    wr(9, 16'h0000);
    chk("R8 disabled no pulse", 16'(sd), 16'h0);
    wr(6, 16'h0002);
    wr(9, 16'h0001);
    chk("R8 nonzero no pulse", 16'(sd), 16'h0);
    wr(9, 16'h0000);
    chk("R8 pulse", 16'(sd), 16'h1);
    @(negedge clk);
    chk("R8 pulse ends", 16'(sd), 16'h0);
    rd(9, v); chk("R8 wdg reads 0", v, 16'h0000);

    // R9 unimplemented indices
    wr(6, 16'h00C3);
    for (int i = 10; i < 32; i++) begin
      wr(i, 16'hFFFF);
      rd(i, v); chk("R9 unimpl reads 0", v, 16'h0000);
    end
    rd(6, v); chk("R9 ctl1 untouched", v, 16'h00C3);
    rd(2, v); chk("R9 mask untouched", v, 16'hFFFF);
    rd(1, v); chk("R9 status untouched", v, 16'h0000);

    // R10 read latency and hold
    wr(7, 16'hBEEF);
    en = 1; we = 0; idx = 5'd7;
    @(posedge clk); @(negedge clk);
    en = 0;
    chk("R10 data next cycle", rdata, 16'hBEEF);
    repeat (3) @(negedge clk);
    chk("R10 hold idle", rdata, 16'hBEEF);
    wr(7, 16'h1111);
    chk("R10 hold over write", rdata, 16'hBEEF);

    summary();
  end
endmodule